// File: doc/BRIEF.md
# Synchronous Burst Read Controller

This block is a clocked read engine for a flash-style memory. A host presents an address and pulses an active-low address strobe. The block captures the address and waits a programmable number of clock edges. It then delivers one data word per rising clock edge, and a wait flag marks every cycle in which the delivered word is not yet valid. A 16-bit read configuration register selects the behaviour. It chooses between clocked burst reads and a plain single-word read mode. It also sets the initial latency, the burst span (8 words, 16 words or unbounded) and the electrical sense of the wait flag.

Bursts of 8 or 16 words wrap inside the aligned block that holds the start address. Unbounded bursts keep counting upward. A read aimed at the status word instead of the array returns that one word on every beat of the burst. Raising output enable or deselecting the chip ends the burst and releases the data bus. A fresh strobe abandons any burst in progress and starts a new one. Writes to the configuration register that arrive while a burst is active are held back until the block is idle. The array is a behavioural word generator.

Top module: `burst_rd_ctrl`

## Requirements
- R1: After synchronous reset the configuration word is 16'h9807: single-word mode, latency 3, unbounded span, low-true wait. In this state `rdata_drive` is 0 and `data_wait` is 1, which is the deasserted level.
- R2: Configuration fields: bit 15 selects single-word mode when 1 and burst mode when 0. Bits 13:11 hold the latency L, and code 0 acts as 1. Bit 10 is the level that marks wait as asserted. Bits 2:0 select the span: 3'b011 gives 16 words, 3'b111 gives unbounded, and any other code gives 8 words. All other bits are ignored.
- R3: The address is captured on the first rising edge at which `addr_vld_n` and `chip_sel_n` are both low. Later edges with the strobe still low capture nothing. A new capture needs the strobe to be seen high first. A strobe seen while `chip_sel_n` is high starts nothing.
- R4: In burst mode, word j (counting from 0) is on `rdata` after the (L+j)-th rising edge that follows the capture edge.
- R5: In burst mode, `data_wait` sits at the asserted level (bit 10) from the capture edge until the first word appears. It sits at the opposite level while words are delivered and whenever the block is idle.
- R6: In single-word mode, the word at the captured address appears after the first edge that follows capture. It then stays unchanged until the read ends, and `data_wait` never asserts.
- R7: With an 8- or 16-word span, addresses wrap inside the aligned block of that size. After the last word has been shown for one cycle, `rdata_drive` drops to 0.
- R8: With the unbounded span, the address increments by one each beat, modulo 2^AW, and crosses block boundaries.
- R9: When `reg_sel` is 1 at capture, every beat returns the status word 16'h0080 for the full span.
- R10: While a read is active, `out_en_n` high releases `rdata_drive` at once, and the block is idle after the next edge. A new capture during a burst restarts it at the new address with the full latency.
- R11: A configuration write on an edge where a burst is active or starting changes nothing in that read. It takes effect on the first edge after the block has returned to idle.
- R12: The array word at address a is (a * 16'h9E37 + 16'h1234) truncated to DW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr_vld_n | input | 1 | Address strobe, active low |
| addr | input | AW | Word address |
| reg_sel | input | 1 | 1 selects the status word instead of the array |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| rdata | output | DW | Read data, 0 while not driven |
| rdata_drive | output | 1 | High when the data bus is driven |
| data_wait | output | 1 | Wait flag, sense set by configuration bit 10 |

## Verification
The assertions assume the address strobe and the enables are sampled synchronously, so a strobe pulse must span at least one rising edge. They also assume output enable is low from capture onward in any read whose data is checked. The bench drives every input on falling edges, holds the strobe low across at least one rising edge, and lowers output enable before each strobe. It raises output enable only to end a read on purpose. Configuration writes are issued either while idle or on a capture edge, which exercises the deferral path.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAT,
        ST_DATA,
        ST_HOLD
    } bst_e;

    typedef enum logic [1:0] {
        BL_8,
        BL_16,
        BL_CONT
    } blen_e;

    typedef struct packed {
        logic       single_md;
        logic [2:0] lat;
        logic       wait_hi;
        blen_e      blen;
    } rcfg_t;

    localparam int          CFG_W   = 16;
    localparam logic [15:0] CFG_RST = 16'h9807;

    function automatic rcfg_t decode_cfg(input logic [CFG_W-1:0] w);
        rcfg_t r;
        r.single_md = w[15];
        r.lat       = (w[13:11] == 3'd0) ? 3'd1 : w[13:11];
        r.wait_hi   = w[10];
        case (w[2:0])
            3'b011:  r.blen = BL_16;
            3'b111:  r.blen = BL_CONT;
            default: r.blen = BL_8;
        endcase
        return r;
    endfunction

    function automatic logic [4:0] span_words(input blen_e b);
        case (b)
            BL_8:    return 5'd8;
            BL_16:   return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/brc_cfg_reg.sv
module brc_cfg_reg
    import brc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             busy,
    output rcfg_t            cfg_o
);
    rcfg_t cfg_q;
    rcfg_t pend_q;
    logic  pend_vld_q;
    logic  unused_rsv;

    assign unused_rsv = ^{wdata[14], wdata[9:3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= decode_cfg(CFG_RST);
            pend_q     <= decode_cfg(CFG_RST);
            pend_vld_q <= 1'b0;
        end else if (we && !busy) begin
            cfg_q      <= decode_cfg(wdata);
            pend_vld_q <= 1'b0;
        end else if (we) begin
            pend_q     <= decode_cfg(wdata);
            pend_vld_q <= 1'b1;
        end else if (pend_vld_q && !busy) begin
            cfg_q      <= pend_q;
            pend_vld_q <= 1'b0;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/brc_addr_seq.sv
module brc_addr_seq
    import brc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  blen_e         blen,
    output logic [AW-1:0] cur_o
);
    logic [AW-1:0] cur_q;
    logic [AW-1:0] mask;
    logic [AW-1:0] nxt;

    always_comb begin
        case (blen)
            BL_8:    mask = AW'(7);
            BL_16:   mask = AW'(15);
            default: mask = '1;
        endcase
        nxt = (cur_q & ~mask) | ((cur_q + AW'(1)) & mask);
    end

    always_ff @(posedge clk) begin
        if (rst)       cur_q <= '0;
        else if (load) cur_q <= load_addr;
        else if (step) cur_q <= nxt;
    end

    assign cur_o = cur_q;
endmodule

// File: rtl/brc_array_model.sv
module brc_array_model #(
    parameter int             AW          = 8,
    parameter int             DW          = 16,
    parameter logic [DW-1:0]  STATUS_WORD = DW'(16'h0080)
) (
    input  logic [AW-1:0] addr,
    input  logic          sel_status,
    output logic [DW-1:0] word_o
);
    localparam logic [31:0] MULT = 32'h0000_9E37;
    localparam logic [31:0] OFS  = 32'h0000_1234;

    logic [31:0] prod;
    logic        unused_hi;

    assign prod      = 32'(addr) * MULT + OFS;
    assign unused_hi = ^prod;
    assign word_o    = sel_status ? STATUS_WORD : prod[DW-1:0];
endmodule

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl
    import brc_pkg::*;
#(
    parameter int            AW          = 8,
    parameter int            DW          = 16,
    parameter logic [DW-1:0] STATUS_WORD = DW'(16'h0080)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chip_sel_n,
    input  logic             out_en_n,
    input  logic             addr_vld_n,
    input  logic [AW-1:0]    addr,
    input  logic             reg_sel,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [DW-1:0]    rdata,
    output logic             rdata_drive,
    output logic             data_wait
);
    rcfg_t         cfg_q;
    bst_e          st_q;
    logic          strobe_held_q;
    logic [2:0]    wcnt_q;
    logic [2:0]    lat_q;
    logic [4:0]    beat_q;
    logic          last_q;
    logic          single_q;
    logic          sel_q;
    blen_e         blen_q;
    logic [DW-1:0] data_q;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] arr_word;
    logic          start;
    logic          stop_now;
    logic          busy;
    logic          take_word;

    assign start    = !addr_vld_n && !chip_sel_n && !strobe_held_q;
    assign stop_now = (st_q != ST_IDLE) && (out_en_n || chip_sel_n);
    assign busy     = (st_q != ST_IDLE) || start;
    assign take_word = !start && !stop_now &&
                       (((st_q == ST_LAT) && (wcnt_q == 3'd0)) ||
                        ((st_q == ST_DATA) && !last_q));

    brc_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .busy  (busy),
        .cfg_o (cfg_q)
    );

    brc_addr_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_addr (addr),
        .step      (take_word),
        .blen      (blen_q),
        .cur_o     (cur_addr)
    );

    brc_array_model #(.AW(AW), .DW(DW), .STATUS_WORD(STATUS_WORD)) u_arr (
        .addr       (cur_addr),
        .sel_status (sel_q),
        .word_o     (arr_word)
    );

    // one capture per strobe: armed again only when the strobe is seen high
    always_ff @(posedge clk) begin
        if (rst)             strobe_held_q <= 1'b0;
        else if (addr_vld_n) strobe_held_q <= 1'b0;
        else if (start)      strobe_held_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            wcnt_q   <= '0;
            lat_q    <= '0;
            beat_q   <= '0;
            last_q   <= 1'b0;
            single_q <= 1'b0;
            sel_q    <= 1'b0;
            blen_q   <= BL_8;
            data_q   <= '0;
        end else if (start) begin
            st_q     <= ST_LAT;
            wcnt_q   <= cfg_q.single_md ? 3'd0 : cfg_q.lat - 3'd1;
            lat_q    <= cfg_q.lat;
            beat_q   <= '0;
            last_q   <= 1'b0;
            single_q <= cfg_q.single_md;
            sel_q    <= reg_sel;
            blen_q   <= cfg_q.blen;
        end else if (stop_now) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_LAT: begin
                    if (wcnt_q != 3'd0) begin
                        wcnt_q <= wcnt_q - 3'd1;
                    end else begin
                        data_q <= arr_word;
                        st_q   <= single_q ? ST_HOLD : ST_DATA;
                        beat_q <= beat_q + 5'd1;
                        last_q <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (last_q) begin
                        st_q <= ST_IDLE;
                    end else begin
                        data_q <= arr_word;
                        beat_q <= beat_q + 5'd1;
                        last_q <= (blen_q != BL_CONT) &&
                                  (beat_q == span_words(blen_q) - 5'd1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign rdata_drive = (st_q != ST_IDLE) && !out_en_n && !chip_sel_n;
    assign rdata       = rdata_drive ? data_q : '0;
    assign data_wait   = ((st_q == ST_LAT) && !single_q) ? cfg_q.wait_hi
                                                         : !cfg_q.wait_hi;
endmodule

// File: rtl/burst_rd_ctrl_chk.sv
module burst_rd_ctrl_chk
    import brc_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input bst_e          st,
    input logic          start,
    input logic          single_q,
    input rcfg_t         cfg,
    input blen_e         blen_q,
    input logic [2:0]    lat_q,
    input logic [AW-1:0] cur_addr,
    input logic [DW-1:0] data_q,
    input logic          out_en_n,
    input logic          addr_vld_n,
    input logic          data_wait
);
    logic [3:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)                  since_q <= '0;
        else if (start)           since_q <= 4'd1;
        else if (since_q != 4'hF) since_q <= since_q + 4'd1;
    end

    assert_first_word_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && $past(st) == ST_LAT) |-> (since_q == {1'b0, lat_q} + 4'd1));

    assert_wait_clear_on_data_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (data_wait == !cfg.wait_hi));

    assert_single_no_wait_R6: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && single_q) |-> (data_wait == !cfg.wait_hi));

    assert_single_word_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && $past(st) == ST_HOLD) |-> $stable(data_q));

    assert_wrap_in_block_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && $past(st) == ST_DATA && blen_q == BL_8)
            |-> (cur_addr[AW-1:3] == $past(cur_addr[AW-1:3])));

    assert_oe_ends_read_R10: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && out_en_n && addr_vld_n) |=> (st == ST_IDLE));

    assert_cfg_frozen_in_burst_R11: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(cfg));
endmodule

bind burst_rd_ctrl burst_rd_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .st         (st_q),
    .start      (start),
    .single_q   (single_q),
    .cfg        (cfg_q),
    .blen_q     (blen_q),
    .lat_q      (lat_q),
    .cur_addr   (cur_addr),
    .data_q     (data_q),
    .out_en_n   (out_en_n),
    .addr_vld_n (addr_vld_n),
    .data_wait  (data_wait)
);

// File: tb/burst_rd_ctrl_tb_top.sv
module burst_rd_ctrl_tb_top;
    localparam logic [15:0] STATUS = 16'h0080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_sel_n = 1'b0;
    logic        out_en_n = 1'b0;
    logic        addr_vld_n = 1'b1;
    logic [7:0]  addr = '0;
    logic        reg_sel = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] rdata;
    logic        rdata_drive;
    logic        data_wait;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_rd_ctrl dut_i (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
        .addr_vld_n(addr_vld_n), .addr(addr), .reg_sel(reg_sel),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rdata(rdata),
        .rdata_drive(rdata_drive), .data_wait(data_wait)
    );

    // R12: array word formula
    function automatic logic [15:0] exp_word(input logic [7:0] a);
        logic [31:0] p;
        p = 32'(a) * 32'h9E37 + 32'h1234;
        return p[15:0];
    endfunction

    task automatic chk_eq(input string rq, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic start_read(input logic [7:0] a, input logic sel);
        addr = a;
        reg_sel = sel;
        addr_vld_n = 1'b0;
        step();
        addr_vld_n = 1'b1;
        reg_sel = 1'b0;
    endtask

    // checks from k0 edges after capture: latency, then nw words
    task automatic follow(input logic [7:0] a, input int lat, input int len,
                          input int nw, input logic pol, input logic sel,
                          input int k0, input string rq);
        logic [7:0] ea;
        for (int k = k0; k < lat; k++) begin
            chk_eq(rq, "wait in latency", data_wait, pol);
            chk_eq(rq, "bus driven in latency", rdata_drive, 1);
            step();
        end
        for (int j = 0; j < nw; j++) begin
            if (len == 8)       ea = {a[7:3], 3'(a[2:0] + 3'(j))};
            else if (len == 16) ea = {a[7:4], 4'(a[3:0] + 4'(j))};
            else                ea = 8'(a + 8'(j));
            chk_eq(rq, "burst word", rdata, sel ? STATUS : exp_word(ea));
            chk_eq(rq, "wait with valid data", data_wait, !pol);
            step();
        end
        if (len != 0 && nw == len) begin
            chk_eq(rq, "bus released after span", rdata_drive, 0);
            chk_eq(rq, "wait idle level", data_wait, !pol);
        end
    endtask

    task automatic end_by_oe(input string rq);
        out_en_n = 1'b1;
        #0.1;
        chk_eq(rq, "oe high releases bus", rdata_drive, 0);
        step();
        out_en_n = 1'b0;
        #0.1;
        chk_eq(rq, "idle after oe", rdata_drive, 0);
    endtask

    task automatic t_single(input logic [7:0] a, input logic pol, input string rq);
        start_read(a, 1'b0);
        chk_eq(rq, "single: no wait at capture", data_wait, !pol);
        step();
        chk_eq(rq, "single: word", rdata, exp_word(a));
        chk_eq(rq, "single: no wait", data_wait, !pol);
        step();
        step();
        chk_eq(rq, "single: word held", rdata, exp_word(a));
        chk_eq(rq, "single: still no wait", data_wait, !pol);
        end_by_oe("R10");
    endtask

    task automatic t_reset();
        chk_eq("R1", "reset bus", rdata_drive, 0);
        chk_eq("R1", "reset wait deasserted", data_wait, 1);
    endtask

    task automatic t_wrap8();
        write_cfg(16'h1802); // R2: sync, L=3, low-true, 8 words
        start_read(8'h2D, 1'b0);
        follow(8'h2D, 3, 8, 8, 1'b0, 1'b0, 0, "R4 R7");
    endtask

    task automatic t_wrap16_pol();
        write_cfg(16'h1403); // R2: sync, L=2, high-true, 16 words
        chk_eq("R5", "idle wait high-true", data_wait, 0);
        start_read(8'h4E, 1'b0);
        follow(8'h4E, 2, 16, 16, 1'b1, 1'b0, 0, "R5 R7");
    endtask

    task automatic t_cont();
        write_cfg(16'h2007); // R2: sync, L=4, unbounded
        start_read(8'hFC, 1'b0);
        follow(8'hFC, 4, 0, 10, 1'b0, 1'b0, 0, "R8");
        end_by_oe("R8");
    endtask

    task automatic t_lat_zero();
        write_cfg(16'h0002); // R2: latency code 0 acts as 1
        start_read(8'h71, 1'b0);
        follow(8'h71, 1, 8, 8, 1'b0, 1'b0, 0, "R2");
    endtask

    task automatic t_status();
        write_cfg(16'h1802);
        start_read(8'h33, 1'b1);
        follow(8'h33, 3, 8, 8, 1'b0, 1'b1, 0, "R9");
    endtask

    task automatic t_held_strobe();
        addr = 8'h10;
        addr_vld_n = 1'b0;
        step();
        addr = 8'h90; // R3: must not be captured
        step();
        step();
        addr_vld_n = 1'b1;
        follow(8'h10, 3, 8, 8, 1'b0, 1'b0, 2, "R3");
    endtask

    task automatic t_deselected();
        chip_sel_n = 1'b1;
        addr_vld_n = 1'b0;
        addr = 8'h55;
        step();
        addr_vld_n = 1'b1;
        chk_eq("R3", "no read while deselected", rdata_drive, 0);
        chip_sel_n = 1'b0;
        step();
        chk_eq("R3", "still idle after deselect strobe", rdata_drive, 0);
    endtask

    task automatic t_abort();
        start_read(8'h20, 1'b0);
        follow(8'h20, 3, 8, 2, 1'b0, 1'b0, 0, "R10");
        start_read(8'h60, 1'b0);
        follow(8'h60, 3, 8, 8, 1'b0, 1'b0, 0, "R10");
    endtask

    task automatic t_deferred_cfg();
        addr = 8'h08;
        addr_vld_n = 1'b0;
        cfg_we = 1'b1;
        cfg_wdata = 16'h8400; // single-word, high-true wait
        step();
        addr_vld_n = 1'b1;
        cfg_we = 1'b0;
        follow(8'h08, 3, 8, 8, 1'b0, 1'b0, 0, "R11");
        step();
        chk_eq("R11", "deferred polarity applied when idle", data_wait, 0);
        t_single(8'hA7, 1'b1, "R11");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single(8'h35, 1'b0, "R6");
        t_wrap8();
        t_wrap16_pol();
        t_cont();
        t_lat_zero();
        t_status();
        t_held_strobe();
        t_deselected();
        t_abort();
        t_deferred_cfg();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule